// File: doc/BRIEF.md
# Sequential-Access I2C Configuration Register Slave

This block is an I2C target that holds a small bank of 8-bit configuration registers and drives them onto a parallel bus for the logic around it. It has no register pointer. Every write starts at register 0, and every read starts with a byte count followed by register 0. A host writes by addressing the device. It then sends two bytes that the slave acknowledges and throws away, followed by data bytes that fill the registers in ascending order. The host may end the transfer after any complete byte.

The bus pins are oversampled by the system clock through two-flop synchronizers. START and STOP are recognized as SDA edges while SCL is high. The slave pulls SDA low only through `sda_oe`, which emulates an open-drain output. It moves that output only while SCL is low. The lower `WR_REGS` registers are writable. Any register above them is read-only and keeps its power-on value. All registers return to parameter-given defaults on reset.

Top module: `i2cfg_slave`

## Requirements
- R1: While reset is asserted and directly after it is released, `cfg_o` equals `DEFAULTS`, with register k at bits [8k+7:8k].
- R2: The slave acknowledges (pulls SDA low in the ninth clock) the address byte 0xD2 for writes and 0xD3 for reads, meaning 7-bit address 0x69 with bit 0 as read flag. It does not acknowledge any other address, and it ignores the rest of that transfer, leaving `cfg_o` unchanged.
- R3: After a write address, the next two bytes (a command byte and a count byte) are each acknowledged and their values are stored nowhere.
- R4: Data bytes that follow are written to registers 0, 1, 2 and up in order, each acknowledged, and every START restarts the order at register 0.
- R5: A STOP after any complete byte keeps the registers already written and leaves all others unchanged.
- R6: Data bytes beyond the `WR_REGS` writable registers are acknowledged and discarded. The read-only register(s) above them never change.
- R7: After the read address the slave transmits, MSB first, the byte count `COUNT_BYTE` (default 7), then registers 0 to `NUM_REGS`-1. It sends 0xFF for any byte requested beyond that.
- R8: When the host answers a transmitted byte with NACK (SDA high in the ninth clock), the slave releases SDA and drives nothing until the next START.
- R9: A repeated START, even in the middle of a byte, returns the slave to address reception. Registers completed before it keep their values, and a partial byte is dropped.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain emulation) |
| cfg_o | output | NUM_REGS*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
The bench builds the slave with seven registers and six writable ones, and gives every register a distinct default byte. This puts one read-only register in reach, so the bench can check that it never changes under over-long writes and that it is still read back. With only six writable slots, a short burst of eight data bytes is enough to run past the end. A nine-byte read is enough to pass the last register and reach the 0xFF filler.

// File: rtl/i2cfg_pkg.sv
package i2cfg_pkg;

  // strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic shiftIn;   // shift sampled SDA into the byte register
    logic shiftOut;  // move next transmit bit to the MSB
    logic loadTx;    // load next byte of the read stream
    logic store;     // commit received byte to the current register
    logic clrIdx;    // restart both register indexes at zero
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignore bus until START
    ST_RX,     // receiving eight bits
    ST_ACK,    // slave holds SDA low for the ninth clock
    ST_TX,     // shifting a byte out
    ST_MACK    // host answers ACK or NACK
  } state_t;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } role_t;

endpackage

// File: rtl/i2cfg_ctrl.sv
module i2cfg_ctrl
  import i2cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    strb,
  output logic       sdaBit,
  output logic       sda_oe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl_i};
      sdaSync <= {sdaSync[0], sda_i};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit   = sdaS;

  state_t     st, stN;
  role_t      role, roleN;
  logic [3:0] bitCnt, cntN;
  logic       rdMode, rdN, mAck, mAckN;

  always_comb begin
    strb  = '0;
    stN   = st;
    roleN = role;
    cntN  = bitCnt;
    rdN   = rdMode;
    mAckN = mAck;
    if (startDet) begin
      stN         = ST_RX;
      roleN       = RL_ADDR;
      cntN        = 4'd0;
      strb.clrIdx = 1'b1;
    end else if (stopDet) begin
      stN = ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.shiftIn = 1'b1;
            cntN         = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (role == RL_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stN = ST_ACK;
                rdN = rxByte[0];
              end else begin
                stN = ST_IDLE;
              end
            end else begin
              stN        = ST_ACK;
              strb.store = (role == RL_DATA);
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntN = 4'd0;
            if (role == RL_ADDR && rdMode) begin
              strb.loadTx = 1'b1;
              stN         = ST_TX;
            end else begin
              stN   = ST_RX;
              roleN = (role == RL_DATA) ? RL_DATA : role_t'(role + 2'd1);
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stN = ST_MACK;
            end else begin
              strb.shiftOut = 1'b1;
              cntN          = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckN = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              stN         = ST_TX;
              cntN        = 4'd0;
            end else begin
              stN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      role   <= RL_ADDR;
      bitCnt <= 4'd0;
      rdMode <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st     <= stN;
      role   <= roleN;
      bitCnt <= cntN;
      rdMode <= rdN;
      mAck   <= mAckN;
    end
  end

  assign sda_oe = (st == ST_ACK) | ((st == ST_TX) & ~txBit);

endmodule

// File: rtl/i2cfg_regs.sv
module i2cfg_regs
  import i2cfg_pkg::*;
#(
  parameter int                    NUM_REGS   = 7,
  parameter int                    WR_REGS    = 6,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS   = '0,
  parameter logic [7:0]            COUNT_BYTE = 8'd7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strb,
  input  logic                  sdaBit,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int IDX_W = $clog2(NUM_REGS + 2);
  localparam logic [IDX_W-1:0] WR_LIM  = IDX_W'(WR_REGS);
  localparam logic [IDX_W-1:0] NUM_LIM = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] RD_END  = IDX_W'(NUM_REGS + 1);

  logic [7:0]           shiftReg, txByte;
  logic [IDX_W-1:0]     wrIdx, rdIdx;
  logic [WR_REGS*8-1:0] wrBank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrBank <= DEFAULTS[WR_REGS*8-1:0];
      wrIdx  <= '0;
    end else if (strb.clrIdx) begin
      wrIdx <= '0;
    end else if (strb.store && wrIdx != WR_LIM) begin
      wrBank[wrIdx*8 +: 8] <= shiftReg;
      wrIdx                <= wrIdx + 1'b1;
    end
  end

  generate
    if (NUM_REGS > WR_REGS) begin : g_ro
      assign cfg_o = {DEFAULTS[NUM_REGS*8-1:WR_REGS*8], wrBank};
    end else begin : g_all_rw
      assign cfg_o = wrBank;
    end
  endgenerate

  always_comb begin
    if (rdIdx == '0)           txByte = COUNT_BYTE;
    else if (rdIdx <= NUM_LIM) txByte = cfg_o[(rdIdx - 1'b1)*8 +: 8];
    else                       txByte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= 8'h00;
      rdIdx    <= '0;
    end else begin
      if (strb.clrIdx) rdIdx <= '0;
      if (strb.shiftIn) begin
        shiftReg <= {shiftReg[6:0], sdaBit};
      end else if (strb.shiftOut) begin
        shiftReg <= {shiftReg[6:0], 1'b0};
      end else if (strb.loadTx) begin
        shiftReg <= txByte;
        if (rdIdx != RD_END) rdIdx <= rdIdx + 1'b1;
      end
    end
  end

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[7];

endmodule

// File: rtl/i2cfg_slave.sv
module i2cfg_slave
  import i2cfg_pkg::*;
#(
  parameter int                    NUM_REGS   = 7,
  parameter int                    WR_REGS    = 6,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS   = '0,
  parameter logic [7:0]            COUNT_BYTE = 8'd7,
  parameter logic [6:0]            DEV_ADDR   = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  strobe_t    strb;
  logic       sdaBit, txBit;
  logic [7:0] rxByte;

  i2cfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rxByte(rxByte), .txBit(txBit), .strb(strb),
    .sdaBit(sdaBit), .sda_oe(sda_oe)
  );

  i2cfg_regs #(
    .NUM_REGS(NUM_REGS), .WR_REGS(WR_REGS),
    .DEFAULTS(DEFAULTS), .COUNT_BYTE(COUNT_BYTE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .cfg_o(cfg_o)
  );

endmodule

// File: rtl/i2cfg_slave_chk.sv
module i2cfg_slave_chk #(
  parameter int                    NUM_REGS = 7,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_o
);

  logic [NUM_REGS*8-1:0] prevCfg;
  logic [NUM_REGS-1:0]   regMoved;

  always_ff @(posedge clk) prevCfg <= cfg_o;

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++)
      regMoved[k] = (cfg_o[k*8 +: 8] != prevCfg[k*8 +: 8]);
  end

  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_o == DEFAULTS)
    else $error("R1: registers not at defaults after reset");

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i)
    else $error("R10: sda_oe moved while SCL high");

  p_cfg_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> !scl_i)
    else $error("R4: register written while SCL high");

  p_one_reg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(regMoved))
    else $error("R4: more than one register changed in a cycle");

endmodule

bind i2cfg_slave i2cfg_slave_chk #(
  .NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_o(cfg_o)
);

// File: tb/i2cfg_slave_tb.sv
module i2cfg_slave_tb;

  localparam int NREG = 7;
  localparam int WREG = 6;
  localparam logic [NREG*8-1:0] DEF = 56'h7E_6D_5C_4B_3A_29_18;

  logic clk = 1'b0, rst_n = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaBus;
  logic [NREG*8-1:0] cfg;

  assign sdaBus = sdaM & ~sdaOe;

  i2cfg_slave #(.NUM_REGS(NREG), .WR_REGS(WREG), .DEFAULTS(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(sclM), .sda_i(sdaBus),
    .sda_oe(sdaOe), .cfg_o(cfg)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, oeBad = 0;
  logic [7:0] model [NREG];
  logic [7:0] expQ[$];
  logic [7:0] actQ[$];
  string tagQ[$];
  logic prevOe = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quarter;
    repeat (10) @(negedge clk);
  endtask

  task automatic startCond;
    sdaM = 1'b1; quarter; sclM = 1'b1; quarter; sdaM = 1'b0; quarter; sclM = 1'b0; quarter;
  endtask

  task automatic stopCond;
    sdaM = 1'b0; quarter; sclM = 1'b1; quarter; sdaM = 1'b1; quarter;
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; quarter; sclM = 1'b1; quarter; seen = sdaBus; quarter; sclM = 1'b0; quarter;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    logic s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      v = {v[6:0], s};
    end
    clockBit(nack, s);
  endtask

  // driver side: expected byte goes into the queue before the read
  task automatic readExpect(input logic [7:0] e, input logic nack, input string tag);
    logic [7:0] v;
    expQ.push_back(e);
    tagQ.push_back(tag);
    recvByte(nack, v);
    actQ.push_back(v);
  endtask

  task automatic writeExpectAck(input logic [7:0] v, input string tag);
    logic a;
    sendByte(v, a);
    check(a == 1'b1, tag, a, 1);
  endtask

  task automatic checkCfg(input string tag);
    for (int k = 0; k < NREG; k++)
      check(cfg[k*8 +: 8] == model[k], tag, cfg[k*8 +: 8], model[k]);
  endtask

  task automatic idleBits(input string tag);
    logic s;
    logic [8:0] seen;
    for (int i = 0; i < 9; i++) begin
      clockBit(1'b1, s);
      seen[i] = s;
    end
    check(seen == 9'h1FF, tag, seen, 9'h1FF);
  endtask

  // monitor: compares read bytes against the scoreboard
  always @(negedge clk) begin
    if (actQ.size() > 0 && expQ.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = actQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(a == e, t, a, e);
    end
  end

  // R10: sda_oe must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sdaOe !== prevOe && sclM) oeBad++;
    prevOe = sdaOe;
  end

  bit finished = 1'b0;

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary;
      $finish;
    end
  end

  initial begin
    logic a;
    logic s;
    for (int k = 0; k < NREG; k++) model[k] = DEF[k*8 +: 8];

    repeat (5) @(negedge clk);
    check(cfg == DEF, "R1 in reset", cfg, DEF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkCfg("R1 after reset");

    // write: address, two ignored bytes, three data bytes
    startCond;
    writeExpectAck(8'hD2, "R2 write address ack");
    writeExpectAck(8'hAA, "R3 command byte ack");
    writeExpectAck(8'h55, "R3 count byte ack");
    writeExpectAck(8'h11, "R4 data ack");
    writeExpectAck(8'h22, "R4 data ack");
    writeExpectAck(8'h33, "R4 data ack");
    stopCond;
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    checkCfg("R3 R4 R5 partial write");

    // foreign address is ignored
    startCond;
    sendByte(8'hA0, a);
    check(a == 1'b0, "R2 foreign address nack", a, 0);
    sendByte(8'h99, a);
    check(a == 1'b0, "R2 no ack after foreign address", a, 0);
    sendByte(8'h98, a);
    stopCond;
    checkCfg("R2 registers untouched");

    // overlong write
    startCond;
    writeExpectAck(8'hD2, "R2 write address ack");
    writeExpectAck(8'h01, "R3 command byte ack");
    writeExpectAck(8'h08, "R3 count byte ack");
    for (int i = 0; i < 8; i++) writeExpectAck(8'hF0 + 8'(i), "R6 data ack incl beyond end");
    stopCond;
    for (int i = 0; i < WREG; i++) model[i] = 8'hF0 + 8'(i);
    checkCfg("R6 overlong write");

    // repeated START in mid-byte, then a new write from register 0
    startCond;
    writeExpectAck(8'hD2, "R9 address ack");
    writeExpectAck(8'h00, "R9 command ack");
    writeExpectAck(8'h00, "R9 count ack");
    writeExpectAck(8'hA1, "R9 data ack");
    writeExpectAck(8'hA2, "R9 data ack");
    for (int i = 0; i < 4; i++) clockBit(1'b0, s);
    startCond;
    writeExpectAck(8'hD2, "R9 address after restart");
    writeExpectAck(8'h00, "R9 command ack");
    writeExpectAck(8'h00, "R9 count ack");
    writeExpectAck(8'hC1, "R4 index restarts at 0");
    stopCond;
    model[0] = 8'hC1; model[1] = 8'hA2;
    checkCfg("R9 R4 after restart");

    // full read past the end, NACK on last
    startCond;
    writeExpectAck(8'hD3, "R7 read address ack");
    readExpect(8'd7, 1'b0, "R7 count byte");
    for (int k = 0; k < NREG; k++) readExpect(model[k], 1'b0, "R7 register byte");
    readExpect(8'hFF, 1'b1, "R7 past-end filler");
    idleBits("R8 released after NACK");
    stopCond;

    // early NACK after count byte
    startCond;
    writeExpectAck(8'hD3, "R7 read address ack");
    readExpect(8'd7, 1'b1, "R7 count byte");
    idleBits("R8 silent after early NACK");
    stopCond;

    // write then repeated START into a read
    startCond;
    writeExpectAck(8'hD2, "R9 address ack");
    writeExpectAck(8'h00, "R3 command ack");
    writeExpectAck(8'h00, "R3 count ack");
    writeExpectAck(8'h77, "R4 data ack");
    startCond;
    model[0] = 8'h77;
    writeExpectAck(8'hD3, "R9 read after restart");
    readExpect(8'd7, 1'b0, "R9 count byte");
    readExpect(8'h77, 1'b1, "R9 register 0 after restart");
    stopCond;
    checkCfg("R5 R9 final bank");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);
    check(oeBad == 0, "R10 sda_oe stable while SCL high", oeBad, 0);
    finished = 1'b1;
    summary;
    $finish;
  end

endmodule